// File: doc/BRIEF.md
# Uncore Event Counter Unit

This block is a bank of sixteen 48-bit event counters that software programs through a 64-bit register port. A coherence agent beside it supplies a vector of single-cycle event pulses, one pulse line per 8-bit event code. Each counter selects one code from this vector. It adds one on every cycle where its selected pulse is high, as long as both the unit-wide run bit and its own enable bit are set. A counter never stops by itself: it wraps from all ones to zero. On a wrap the counter sets an overflow flag. Each flag can be cleared by writing a one to it. The flags, after an active-high mask, drive one level interrupt.

Software can preload any counter with a starting value, so that the counter wraps after a chosen number of events. Reading a counter returns its live value. The register request channel is valid/ready. A read is answered on a separate valid/ready response channel one cycle after it is accepted. While the response channel is stalled, the unit holds the pending response unchanged and refuses new requests. A write takes effect in the cycle it is accepted and produces no response.

Top module: `upc_top`

## Requirements
- R1: After reset all counters, the run bit, the per-counter enable bitmask and every overflow flag are 0. Every mask bit is 1, every event selector holds 0xFF, and the interrupt output is low.
- R2: A counter adds exactly one per clock cycle in which its selected event pulse is high, while the run bit (bit 0 at 0x1E00) and its enable bit (bit n at 0x1E04) are both 1.
- R3: The selector for counter n is the byte in bits 8*(n%4)+7 down to 8*(n%4) of the 32-bit selector register at 0x1E80 + 4*(n/4). Selector registers read back the value that was written.
- R4: A counter whose selector holds 0xFF never counts, even when event line 255 pulses.
- R5: When the run bit is 0, no counter changes on events. When the run bit is 1, a counter whose enable bit is 0 does not change either.
- R6: Counter n is read and written as a 64-bit register at 0x1F00 + 8*n. Bits 63:48 read as zero, and writes to those bits are ignored. A write preloads bits 47:0.
- R7: An increment from all ones sets the counter to zero and sets overflow flag n. The flags read back as bits 15:0 of 0x0808.
- R8: Writing to 0x080C clears every flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R9: The interrupt output is high exactly when a flag is set and its mask bit (bit n at 0x0804) is 0.
- R10: If a flag's overflow and its clear happen in the same cycle, the flag ends up set.
- R11: If a software write to a counter and an event increment of that counter happen in the same cycle, the counter takes the written value.
- R12: A request transfers on a cycle where req_valid and req_ready are both high. A read raises rsp_valid on the next cycle. The response stays valid and unchanged until rsp_ready is high. req_ready equals (not rsp_valid) or rsp_ready. Writes never raise rsp_valid. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_rdata | output | 64 | Read response data |
| evt_pulse | input | 256 | Event pulse lines, indexed by event code |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench gives neighbouring byte lanes of one selector register different codes. A design that decoded the lanes the wrong way round would count the wrong events. It drives every event line at once against a counter parked on code 0xFF; a design that indexed line 255 would count. It makes an overflow and its clear meet in one cycle, and a counter write meet an increment in one cycle. A design with the wrong priority would drop the flag, or would store the written value plus one. It writes a value with the top 16 bits set and stalls the response channel. These checks catch leaking upper bits and a response that changes or disappears while it waits.

// File: rtl/upc_pkg.sv
package upc_pkg;
  // Register offsets (byte addresses)
  localparam int unsigned UPC_MASK_OFS   = 32'h0804;
  localparam int unsigned UPC_STAT_OFS   = 32'h0808;
  localparam int unsigned UPC_CLR_OFS    = 32'h080C;
  localparam int unsigned UPC_RUN_OFS    = 32'h1E00;
  localparam int unsigned UPC_ENA_OFS    = 32'h1E04;
  localparam int unsigned UPC_SEL_BASE   = 32'h1E80;
  localparam int unsigned UPC_CNT_BASE   = 32'h1F00;
  localparam int unsigned UPC_SEL_STRIDE = 4;
  localparam int unsigned UPC_CNT_STRIDE = 8;

  typedef enum logic [2:0] {
    HIT_NONE, HIT_MASK, HIT_STAT, HIT_RUN, HIT_ENA, HIT_SEL, HIT_CNT
  } upc_hit_e;
endpackage

// File: rtl/upc_counter.sv
module upc_counter #(
  parameter int CTR_W = 48,
  parameter int EVT_W = 8,
  localparam int NUM_EVT = 1 << EVT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               count_en,
  input  logic [EVT_W-1:0]   sel,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic               wr,
  input  logic [CTR_W-1:0]   wdata,
  output logic [CTR_W-1:0]   cnt,
  output logic               wrap
);
  localparam logic [EVT_W-1:0] SEL_NONE = '1;

  logic inc;
  assign inc  = count_en && (sel != SEL_NONE) && evt_pulse[sel];
  assign wrap = inc && !wr && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (wr)  cnt <= wdata;         // software write beats an increment
    else if (inc) cnt <= cnt + 1'b1;
  end

  // R11: write takes precedence
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> cnt == $past(wdata));
  // R4: null selector holds value
  a_r4_null_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE && !wr) |=> $stable(cnt));
  // R5: gated counter holds value
  a_r5_gated_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !wr) |=> $stable(cnt));
  // R7: wrap lands on zero
  a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0);
endmodule

// File: rtl/upc_ovf.sv
module upc_ovf #(
  parameter int NUM_CTR = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] ovf,
  input  logic [NUM_CTR-1:0] clr,
  input  logic [NUM_CTR-1:0] mask,
  output logic [NUM_CTR-1:0] status,
  output logic               irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr) | ovf;   // overflow beats clear
  end

  assign irq = |(status & ~mask);

  // R7 / R10: an overflow always leaves its flag set
  a_r10_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf != '0) |=> ((status & $past(ovf)) == $past(ovf)));
  // R7: flags rise only on overflow
  a_r7_rise_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(ovf)) == '0));
  // R8: flags fall only where a one was written to the clear register
  a_r8_fall_on_clr: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status) & ~status & ~$past(clr)) == '0));
endmodule

// File: rtl/upc_regs.sv
module upc_regs
  import upc_pkg::*;
#(
  parameter int NUM_CTR = 16,
  parameter int CTR_W   = 48,
  parameter int EVT_W   = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 64,
  localparam int LANES  = 32 / EVT_W,
  localparam int NSEL   = NUM_CTR / LANES,
  localparam int IDX_W  = $clog2(NUM_CTR),
  localparam int SIDX_W = (NSEL > 1) ? $clog2(NSEL) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [DATA_W-1:0]             rsp_rdata,
  input  logic [NUM_CTR-1:0][CTR_W-1:0] cnt_q,
  input  logic [NUM_CTR-1:0]            status_q,
  output logic                          run_en,
  output logic [NUM_CTR-1:0]            ctr_en,
  output logic [NUM_CTR-1:0]            int_mask,
  output logic [NUM_CTR-1:0][EVT_W-1:0] sel_q,
  output logic [NUM_CTR-1:0]            cnt_wr,
  output logic [CTR_W-1:0]              cnt_wdata,
  output logic [NUM_CTR-1:0]            clr_bits
);
  logic req_fire, wr_fire;
  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;
  assign wr_fire   = req_fire && req_write;

  // Address decode
  logic [ADDR_W-1:0] sel_off, cnt_off;
  logic              in_sel, in_cnt, is_clr;
  logic [SIDX_W-1:0] sel_idx;
  logic [IDX_W-1:0]  cnt_idx;
  upc_hit_e          hit;

  assign sel_off = req_addr - ADDR_W'(UPC_SEL_BASE);
  assign cnt_off = req_addr - ADDR_W'(UPC_CNT_BASE);
  assign in_sel  = (sel_off < ADDR_W'(UPC_SEL_STRIDE * NSEL)) && (sel_off[1:0] == 2'b00);
  assign in_cnt  = (cnt_off < ADDR_W'(UPC_CNT_STRIDE * NUM_CTR)) && (cnt_off[2:0] == 3'b000);
  assign sel_idx = SIDX_W'(sel_off >> 2);
  assign cnt_idx = IDX_W'(cnt_off >> 3);
  assign is_clr  = (req_addr == ADDR_W'(UPC_CLR_OFS));

  always_comb begin
    if      (req_addr == ADDR_W'(UPC_MASK_OFS)) hit = HIT_MASK;
    else if (req_addr == ADDR_W'(UPC_STAT_OFS)) hit = HIT_STAT;
    else if (req_addr == ADDR_W'(UPC_RUN_OFS))  hit = HIT_RUN;
    else if (req_addr == ADDR_W'(UPC_ENA_OFS))  hit = HIT_ENA;
    else if (in_sel)                            hit = HIT_SEL;
    else if (in_cnt)                            hit = HIT_CNT;
    else                                        hit = HIT_NONE;
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en   <= 1'b0;
      ctr_en   <= '0;
      int_mask <= '1;
    end else if (wr_fire) begin
      if (hit == HIT_RUN)  run_en   <= req_wdata[0];
      if (hit == HIT_ENA)  ctr_en   <= req_wdata[NUM_CTR-1:0];
      if (hit == HIT_MASK) int_mask <= req_wdata[NUM_CTR-1:0];
    end
  end

  // Event selectors: one byte lane per counter
  for (genvar n = 0; n < NUM_CTR; n++) begin : g_sel
    localparam int REG_N  = n / LANES;
    localparam int LANE_N = n % LANES;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sel_q[n] <= '1;
      else if (wr_fire && hit == HIT_SEL && sel_idx == SIDX_W'(REG_N))
        sel_q[n] <= req_wdata[LANE_N*EVT_W +: EVT_W];
    end
  end

  // Counter write strobes and overflow clear strobes
  for (genvar n = 0; n < NUM_CTR; n++) begin : g_wr
    assign cnt_wr[n] = wr_fire && (hit == HIT_CNT) && (cnt_idx == IDX_W'(n));
  end
  assign cnt_wdata = req_wdata[CTR_W-1:0];
  assign clr_bits  = (wr_fire && is_clr) ? req_wdata[NUM_CTR-1:0] : '0;

  // Read mux
  logic [DATA_W-1:0] rd_data;
  logic [31:0]       sel_word;
  always_comb begin
    sel_word = '0;
    for (int l = 0; l < LANES; l++)
      sel_word[l*EVT_W +: EVT_W] = sel_q[int'(sel_idx)*LANES + l];
  end

  always_comb begin
    case (hit)
      HIT_MASK: rd_data = DATA_W'(int_mask);
      HIT_STAT: rd_data = DATA_W'(status_q);
      HIT_RUN:  rd_data = DATA_W'(run_en);
      HIT_ENA:  rd_data = DATA_W'(ctr_en);
      HIT_SEL:  rd_data = DATA_W'(sel_word);
      HIT_CNT:  rd_data = DATA_W'(cnt_q[cnt_idx]);
      default:  rd_data = '0;
    endcase
  end

  // Read response channel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (req_fire && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R12: a stalled response is held unchanged
  a_r12_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  // R12: a write never produces a response
  a_r12_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && rsp_ready) |=> !rsp_valid);
endmodule

// File: rtl/upc_top.sv
module upc_top #(
  parameter int NUM_CTR = 16,
  parameter int CTR_W   = 48,
  parameter int EVT_W   = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 64,
  localparam int NUM_EVT = 1 << EVT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_rdata,
  input  logic [NUM_EVT-1:0] evt_pulse,
  output logic               irq
);
  logic [NUM_CTR-1:0][CTR_W-1:0] cnt_q;
  logic [NUM_CTR-1:0][EVT_W-1:0] sel_q;
  logic [NUM_CTR-1:0]            status_q, ctr_en, int_mask, cnt_wr, clr_bits, wrap;
  logic [CTR_W-1:0]              cnt_wdata;
  logic                          run_en;

  upc_regs #(
    .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .EVT_W(EVT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
    .rsp_valid, .rsp_ready, .rsp_rdata,
    .cnt_q, .status_q, .run_en, .ctr_en, .int_mask, .sel_q,
    .cnt_wr, .cnt_wdata, .clr_bits
  );

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
    upc_counter #(.CTR_W(CTR_W), .EVT_W(EVT_W)) u_ctr (
      .clk, .rst_n,
      .count_en (run_en && ctr_en[n]),
      .sel      (sel_q[n]),
      .evt_pulse,
      .wr       (cnt_wr[n]),
      .wdata    (cnt_wdata),
      .cnt      (cnt_q[n]),
      .wrap     (wrap[n])
    );
  end

  upc_ovf #(.NUM_CTR(NUM_CTR)) u_ovf (
    .clk, .rst_n, .ovf(wrap), .clr(clr_bits), .mask(int_mask),
    .status(status_q), .irq
  );

  // R1: interrupt quiet while every mask bit is set
  a_r1_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&int_mask) |-> !irq);
endmodule

// File: tb/tb_upc_top.sv
module tb_upc_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [15:0]  req_addr = '0;
  logic [63:0]  req_wdata = '0;
  logic         req_ready, rsp_valid, irq;
  logic [63:0]  rsp_rdata;
  logic [255:0] evt_pulse = '0;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;   // 125 MHz

  upc_top dut (.*);

  localparam logic [15:0] A_MASK = 16'h0804, A_STAT = 16'h0808, A_CLR = 16'h080C,
                          A_RUN = 16'h1E00, A_ENA = 16'h1E04, A_SEL0 = 16'h1E80,
                          A_SEL3 = 16'h1E8C;

  function automatic logic [15:0] a_cnt(int n);
    return 16'h1F00 + 16'(8 * n);
  endfunction

  function automatic logic [255:0] ev(int a, int b = -1, int c = -1);
    logic [255:0] m = '0;
    m[a] = 1'b1;
    if (b >= 0) m[b] = 1'b1;
    if (c >= 0) m[c] = 1'b1;
    return m;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [63:0] d, logic [255:0] e = '0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; evt_pulse = e;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0; evt_pulse = '0;
  endtask

  task automatic rd(logic [15:0] a, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    d = rsp_rdata;
  endtask

  task automatic rd_chk(string req, logic [15:0] a, logic [63:0] exp);
    logic [63:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic pulses(logic [255:0] m, int cycles);
    @(negedge clk);
    evt_pulse = m;
    repeat (cycles) @(posedge clk);
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic t_reset;
    chk("R1 irq", {63'd0, irq}, 64'd0);
    rd_chk("R1 run", A_RUN, 64'd0);
    rd_chk("R1 enables", A_ENA, 64'd0);
    rd_chk("R1 mask", A_MASK, 64'h0000_0000_0000_FFFF);
    rd_chk("R1 status", A_STAT, 64'd0);
    rd_chk("R1 selector", A_SEL0, 64'h0000_0000_FFFF_FFFF);
    rd_chk("R1 counter", a_cnt(15), 64'd0);
  endtask

  task automatic t_count_and_lanes;
    wr(A_SEL0, 64'h0000_0000_FFFF_2110);   // ctr0=0x10 ctr1=0x21 ctr2=0xFF
    wr(A_SEL3, 64'h0000_0000_40FF_FFFF);   // ctr15=0x40
    wr(A_ENA, 64'h8007);
    wr(A_RUN, 64'h1);
    pulses(ev(8'h10, 8'h21, 8'h40), 2);
    pulses(ev(8'h10), 3);
    rd_chk("R2 ctr0 count", a_cnt(0), 64'd5);
    rd_chk("R3 ctr1 lane1", a_cnt(1), 64'd2);
    rd_chk("R3 ctr15 reg3 lane3", a_cnt(15), 64'd2);
    rd_chk("R3 selector readback", A_SEL0, 64'h0000_0000_FFFF_2110);
  endtask

  task automatic t_null_code;
    pulses('1, 4);
    rd_chk("R4 null selector", a_cnt(2), 64'd0);
    rd_chk("R2 all lines ctr0", a_cnt(0), 64'd9);
  endtask

  task automatic t_gating;
    wr(A_RUN, 64'h0);
    pulses('1, 3);
    rd_chk("R5 run off ctr0", a_cnt(0), 64'd9);
    rd_chk("R5 run off ctr1", a_cnt(1), 64'd6);
    wr(A_RUN, 64'h1);
    wr(A_ENA, 64'h8002);
    pulses('1, 2);
    rd_chk("R5 ctr0 disabled", a_cnt(0), 64'd9);
    rd_chk("R5 ctr1 enabled", a_cnt(1), 64'd8);
  endtask

  task automatic t_preload;
    wr(a_cnt(1), 64'hABCD_1234_5678_9ABC);
    rd_chk("R6 upper bits zero", a_cnt(1), 64'h0000_1234_5678_9ABC);
  endtask

  task automatic t_wrap_irq;
    wr(A_ENA, 64'h0001);
    wr(a_cnt(0), 64'h0000_FFFF_FFFF_FFFE);
    pulses(ev(8'h10), 2);
    rd_chk("R7 wrapped to zero", a_cnt(0), 64'd0);
    rd_chk("R7 status set", A_STAT, 64'h1);
    chk("R9 masked irq low", {63'd0, irq}, 64'd0);
    wr(A_MASK, 64'hFFFE);
    #1 chk("R9 unmasked irq high", {63'd0, irq}, 64'd1);
    wr(A_CLR, 64'h0002);
    rd_chk("R8 zero bits ignored", A_STAT, 64'h1);
    chk("R9 irq still high", {63'd0, irq}, 64'd1);
    wr(A_CLR, 64'h0001);
    rd_chk("R8 cleared", A_STAT, 64'h0);
    chk("R9 irq low after clear", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_ovf_vs_clr;
    wr(a_cnt(0), 64'h0000_FFFF_FFFF_FFFF);
    wr(A_CLR, 64'h0001, ev(8'h10));
    rd_chk("R10 overflow wins", A_STAT, 64'h1);
    rd_chk("R10 ctr0 wrapped", a_cnt(0), 64'd0);
    wr(A_CLR, 64'h0001);
  endtask

  task automatic t_write_wins;
    wr(a_cnt(0), 64'd100, ev(8'h10));
    rd_chk("R11 write beats increment", a_cnt(0), 64'd100);
  endtask

  task automatic t_backpressure;
    wr(A_RUN, 64'h1);
    @(negedge clk);
    chk("R12 write gives no response", {63'd0, rsp_valid}, 64'd0);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = a_cnt(15);
    @(posedge clk); #1;
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 held valid", {63'd0, rsp_valid}, 64'd1);
    chk("R12 ready low while stalled", {63'd0, req_ready}, 64'd0);
    chk("R12 held data", rsp_rdata, 64'd8);
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    chk("R12 drained", {63'd0, rsp_valid}, 64'd0);
    rd_chk("R12 unmapped reads zero", 16'h0100, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count_and_lanes();
    t_null_code();
    t_gating();
    t_preload();
    t_wrap_irq();
    t_ovf_vs_clr();
    t_write_wins();
    t_backpressure();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule